// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block moves a chosen set of registers between a 16-entry, 32-bit register file and word-addressed memory. It does one memory word per accepted beat. A start pulse captures the whole command: base register index, base value, a 16-bit register set mask, direction (load or store), an addressing mode, a write-back flag and a status-restore flag. The sequencer then walks the mask from the lowest register number upward. It reads the register file for stores and writes it for loads. If needed, it finishes with one cycle that writes the updated base back. A single-cycle done pulse ends every command.

The addressing mode comes in two forms, selected by a stack flag. In the plain form the block takes an increment/decrement bit and a before/after bit. In the stack form the same two pins mean ascending/descending and full/empty. The block turns them into the plain form, taking into account whether the command pushes or pops.

The memory side is a valid/ready stream. While `mem_valid_o` is high, the address, write strobe and write data stay unchanged until `mem_ready_i` is seen high at a clock edge. The memory may hold ready low for any number of cycles. On a load, read data is taken from `mem_rdata_i` in the same beat in which ready is high. The register file read port is combinational.

Top module: `multi_xfer_seq`

## Requirements
- R1: Selected registers go to consecutive words, 4 bytes apart. The lowest-numbered register always goes to the lowest address and the rest follow in rising register order, in every mode.
- R2: In plain mode (`stack_i`=0), `up_i`=1 means increment and `pre_i`=1 means before. The first transfer address is: base (increment-after); base+4 (increment-before); base−4n+4 (decrement-after); base−4n (decrement-before), where n is the number of mask bits set.
- R3: In stack mode (`stack_i`=1), `up_i`=1 means ascending and `pre_i`=1 means full. A store uses the pins as increment/before unchanged. A load inverts both bits. Examples: full-descending pop is increment-after; empty-ascending pop is decrement-before.
- R4: With `wback_i`=1, the base register ends at base+4n (increment) or base−4n (decrement). With `wback_i`=0, the base register keeps its value.
- R5: A store of the base register writes the original base value when write-back is off, or when the base is the lowest-numbered register in the mask. Otherwise it writes the updated base value.
- R6: A load whose mask includes the base register leaves the loaded value in the base register, with or without write-back.
- R7: A load of register 15 with `restore_i`=0 replaces only bits 25 down to 2 and keeps the other bits. With `restore_i`=1 it replaces all 32 bits.
- R8: A store of any register other than the base, register 15 included, writes all 32 bits of the register file value.
- R9: While `mem_valid_o` is high and `mem_ready_i` is low, the request address and write strobe hold steady. Exactly one word moves per beat with both high.
- R10: An all-zero mask makes no memory request and no register write. `done_o` rises in the cycle after the start edge.
- R11: A start while `busy_o` is high is ignored.
- R12: `done_o` is a single-cycle pulse after the last transfer, or after the base write-back when one is needed. `busy_o` is high from the cycle after an accepted start until `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command start pulse |
| load_i | input | 1 | 1 = load from memory, 0 = store |
| stack_i | input | 1 | 1 = stack form of the mode pins |
| up_i | input | 1 | Increment (plain) or ascending (stack) |
| pre_i | input | 1 | Before (plain) or full (stack) |
| wback_i | input | 1 | Write updated base back |
| restore_i | input | 1 | Load all 32 bits of register 15 |
| base_idx_i | input | 4 | Base register number |
| base_val_i | input | 32 | Current base register value |
| mask_i | input | 16 | Register set, bit i selects register i |
| mem_valid_o | output | 1 | Memory beat request valid |
| mem_ready_i | input | 1 | Memory accepts beat |
| mem_addr_o | output | 32 | Byte address of the beat |
| mem_we_o | output | 1 | 1 = write beat |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready on a load |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data |
| rf_we_o | output | 1 | Register file write strobe |
| rf_wr_idx_o | output | 4 | Register file write index |
| rf_wr_data_o | output | 32 | Register file write data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command complete pulse |

## Verification
Each of the four plain modes is exercised with the same three-register mask, for both stores and loads, so that a swapped before/after or a wrong decrement offset shows up as a shifted address. All eight stack-mode push/pop combinations are run; these separate a correct store/load inversion from an uninverted one. The base-register cases store a mask where the base is lowest, one where it is not, and one without write-back, and load it with and without write-back. Register 15 is loaded with and without the restore flag from a word whose bits all differ from the old value, which exposes a wrong field boundary. Random commands under random ready back-pressure cover sparse and dense masks, an empty mask, and a start injected while busy.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } mxs_state_e;

  // Primary addressing mode: up = increment, pre = adjust before transfer
  typedef struct packed {
    logic up;
    logic pre;
  } mxs_mode_t;
endpackage

// File: rtl/mxs_mode_map.sv
module mxs_mode_map
  import mxs_pkg::*;
(
  input  logic      stack_i,
  input  logic      load_i,
  input  logic      up_i,
  input  logic      pre_i,
  output mxs_mode_t mode_o
);
  // A pop on a stack walks opposite to its push: both bits invert.
  logic flip;
  always_comb begin
    flip       = stack_i & load_i;
    mode_o.up  = up_i ^ flip;
    mode_o.pre = pre_i ^ flip;
  end
endmodule

// File: rtl/mxs_lowbit.sv
module mxs_lowbit #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // Index of the lowest set bit; zero when the vector is empty.
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/mxs_addr_gen.sv
module mxs_addr_gen
  import mxs_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [DW-1:0]   base_i,
  input  logic [NREG-1:0] mask_i,
  input  mxs_mode_t       mode_i,
  output logic [DW-1:0]   first_o,
  output logic [DW-1:0]   final_o
);
  localparam int CW = $clog2(NREG + 1);
  localparam int SH = $clog2(WORD_BYTES);
  localparam logic [DW-1:0] STEP = DW'(WORD_BYTES);

  logic [CW-1:0] cnt;
  logic [DW-1:0] span;
  logic [DW-1:0] low_dn;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(mask_i[i]);
    span   = DW'(cnt) << SH;
    low_dn = base_i - span;
    // The lowest address is settled first; transfers then climb from it.
    unique case ({mode_i.up, mode_i.pre})
      2'b10:   first_o = base_i;
      2'b11:   first_o = base_i + STEP;
      2'b00:   first_o = low_dn + STEP;
      default: first_o = low_dn;
    endcase
    final_o = mode_i.up ? (base_i + span) : low_dn;
  end
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import mxs_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int PC_LO      = 2,
  parameter int PC_HI      = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     load_i,
  input  logic                     stack_i,
  input  logic                     up_i,
  input  logic                     pre_i,
  input  logic                     wback_i,
  input  logic                     restore_i,
  input  logic [$clog2(NREG)-1:0]  base_idx_i,
  input  logic [DW-1:0]            base_val_i,
  input  logic [NREG-1:0]          mask_i,
  output logic                     mem_valid_o,
  input  logic                     mem_ready_i,
  output logic [DW-1:0]            mem_addr_o,
  output logic                     mem_we_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic [$clog2(NREG)-1:0]  rf_rd_idx_o,
  input  logic [DW-1:0]            rf_rd_data_i,
  output logic                     rf_we_o,
  output logic [$clog2(NREG)-1:0]  rf_wr_idx_o,
  output logic [DW-1:0]            rf_wr_data_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int IW     = $clog2(NREG);
  localparam int PC_IDX = NREG - 1;
  localparam logic [DW-1:0] STEP     = DW'(WORD_BYTES);
  localparam logic [DW-1:0] PC_FIELD =
    ((DW'(1) << (PC_HI + 1)) - DW'(1)) & ~((DW'(1) << PC_LO) - DW'(1));

  mxs_mode_t mode;
  logic [DW-1:0] first_addr, final_base;
  logic [IW-1:0] start_low, cur_idx;

  mxs_state_e    state_q;
  logic [NREG-1:0] rem_q, rem_nxt;
  logic [DW-1:0] addr_q, base_q, new_base_q;
  logic [IW-1:0] bidx_q;
  logic          load_q, wback_q, restore_q, base_hit_q, base_low_q, done_q;

  mxs_mode_map u_map (
    .stack_i (stack_i),
    .load_i  (load_i),
    .up_i    (up_i),
    .pre_i   (pre_i),
    .mode_o  (mode)
  );

  mxs_addr_gen #(.NREG(NREG), .DW(DW), .WORD_BYTES(WORD_BYTES)) u_agen (
    .base_i  (base_val_i),
    .mask_i  (mask_i),
    .mode_i  (mode),
    .first_o (first_addr),
    .final_o (final_base)
  );

  mxs_lowbit #(.N(NREG)) u_low_cmd (
    .vec_i (mask_i),
    .idx_o (start_low)
  );

  mxs_lowbit #(.N(NREG)) u_low_rem (
    .vec_i (rem_q),
    .idx_o (cur_idx)
  );

  logic wb_needed, in_xfer, cur_is_base;

  always_comb begin
    rem_nxt          = rem_q;
    rem_nxt[cur_idx] = 1'b0;
    wb_needed        = wback_q && !(load_q && base_hit_q);
    in_xfer          = (state_q == ST_XFER);
    cur_is_base      = (cur_idx == bidx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      addr_q     <= '0;
      base_q     <= '0;
      new_base_q <= '0;
      bidx_q     <= '0;
      load_q     <= 1'b0;
      wback_q    <= 1'b0;
      restore_q  <= 1'b0;
      base_hit_q <= 1'b0;
      base_low_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            load_q     <= load_i;
            wback_q    <= wback_i;
            restore_q  <= restore_i;
            bidx_q     <= base_idx_i;
            base_q     <= base_val_i;
            new_base_q <= final_base;
            rem_q      <= mask_i;
            addr_q     <= first_addr;
            base_hit_q <= mask_i[base_idx_i];
            base_low_q <= (start_low == base_idx_i);
            if (mask_i == '0) done_q  <= 1'b1;
            else              state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ready_i) begin
            rem_q  <= rem_nxt;
            addr_q <= addr_q + STEP;
            if (rem_nxt == '0) begin
              if (wb_needed) begin
                state_q <= ST_WB;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
        end
        ST_WB: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid_o = in_xfer;
    mem_addr_o  = addr_q;
    mem_we_o    = in_xfer && !load_q;
    rf_rd_idx_o = cur_idx;
    if (cur_is_base)
      mem_wdata_o = (wback_q && !base_low_q) ? new_base_q : base_q;
    else
      mem_wdata_o = rf_rd_data_i;

    rf_we_o = (in_xfer && load_q && mem_ready_i) || (state_q == ST_WB);
    if (state_q == ST_WB) begin
      rf_wr_idx_o  = bidx_q;
      rf_wr_data_o = new_base_q;
    end else begin
      rf_wr_idx_o = cur_idx;
      if ((cur_idx == IW'(PC_IDX)) && !restore_q)
        rf_wr_data_o = (rf_rd_data_i & ~PC_FIELD) | (mem_rdata_i & PC_FIELD);
      else
        rf_wr_data_o = mem_rdata_i;
    end
    busy_o = (state_q != ST_IDLE);
    done_o = done_q;
  end
endmodule

// File: rtl/mxs_chk.sv
module mxs_chk #(
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic          rf_we_o,
  input logic          busy_o,
  input logic          done_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_valid_o && mem_ready_i) && mem_valid_o |-> mem_addr_o == $past(mem_addr_o) + DW'(WORD_BYTES));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !mem_valid_o);

  // R6
  rf_load_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o && mem_valid_o |-> mem_ready_i && !mem_we_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_valid_o && !rf_we_o);
endmodule

bind multi_xfer_seq mxs_chk #(.DW(DW), .WORD_BYTES(WORD_BYTES)) u_mxs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .rf_we_o     (rf_we_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/multi_xfer_seq_bench.sv
`timescale 1ns/1ps
module multi_xfer_seq_bench;
  localparam logic [31:0] PCM = 32'h03FF_FFFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start_i = 0, load_i = 0, stack_i = 0, up_i = 0, pre_i = 0;
  logic wback_i = 0, restore_i = 0, mem_ready_i = 0;
  logic [3:0] base_idx_i = '0;
  logic [31:0] base_val_i = '0;
  logic [15:0] mask_i = '0;
  logic mem_valid_o, mem_we_o, rf_we_o, busy_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rd_data_i, rf_wr_data_o;
  logic [3:0] rf_rd_idx_o, rf_wr_idx_o;

  logic [31:0] rf [16];
  logic [31:0] mem [1024];
  assign mem_rdata_i  = mem[mem_addr_o[11:2]];
  assign rf_rd_data_i = rf[rf_rd_idx_o];

  multi_xfer_seq u_multi_xfer_seq (.*);

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit ld, input bit stk, input bit up, input bit pre, input bit wb,
                        input bit rs, input int bidx, input logic [15:0] m, input bit inject,
                        input string tag);
    logic [31:0] ea [16];
    logic [31:0] ew [16];
    logic [31:0] erf [16];
    logic [31:0] base, nb, lo, v;
    bit inc, bef, lowest, seen;
    int n, k, cyc;
    inc = (stk && ld) ? !up : up;
    bef = (stk && ld) ? !pre : pre;
    rf[bidx] = 32'h800 + ($urandom % 256) * 4;
    base = rf[bidx];
    n = $countones(m);
    lo = inc ? (bef ? base + 4 : base) : (bef ? base - 4 * n : base - 4 * n + 4);
    nb = inc ? base + 4 * n : base - 4 * n;
    lowest = 0; seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i] && !seen) begin seen = 1; lowest = (i == bidx); end
      erf[i] = rf[i];
    end
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        ea[k] = lo + 4 * k;
        if (!ld) ew[k] = (i == bidx) ? ((wb && !lowest) ? nb : base) : rf[i];
        else begin
          v = mem[ea[k][11:2]];
          erf[i] = (i == 15 && !rs) ? ((rf[15] & ~PCM) | (v & PCM)) : v;
        end
        k++;
      end
    end
    if (wb && !(ld && m[bidx])) erf[bidx] = nb;

    load_i = ld; stack_i = stk; up_i = up; pre_i = pre; wback_i = wb; restore_i = rs;
    base_idx_i = 4'(bidx); base_val_i = base; mask_i = m; start_i = 1;
    @(negedge clk);
    start_i = 0;
    k = 0; cyc = 0;
    forever begin
      if (inject && cyc == 2) begin start_i = 1; load_i = !ld; mask_i = 16'hFFFF; end
      else start_i = 0;
      mem_ready_i = ($urandom % 4) != 0;
      #1;
      if (cyc == 0 && n != 0) chk(busy_o == 1'b1, {tag, " R12 busy after start"}, 32'(busy_o), 1);
      if (n == 0 && cyc == 0) chk(done_o == 1'b1, {tag, " R10 done next cycle"}, 32'(done_o), 1);
      if (done_o) break;
      if (mem_valid_o && mem_ready_i) begin
        if (k >= n) chk(0, {tag, " R11 extra beat"}, mem_addr_o, 0);
        else begin
          chk(mem_addr_o == ea[k], {tag, " R1 R2 beat address"}, mem_addr_o, ea[k]);
          chk(mem_we_o == !ld, {tag, " R9 beat direction"}, 32'(mem_we_o), 32'(!ld));
          if (!ld) chk(mem_wdata_o == ew[k], {tag, " R5 R8 store data"}, mem_wdata_o, ew[k]);
        end
        if (mem_we_o) mem[mem_addr_o[11:2]] = mem_wdata_o;
        k++;
      end
      if (rf_we_o) rf[rf_wr_idx_o] = rf_wr_data_o;
      @(negedge clk);
      cyc++;
      if (cyc > 600) begin chk(0, {tag, " R12 done timeout"}, 32'(cyc), 0); break; end
    end
    start_i = 0;
    chk(k == n, {tag, " R9 beat count"}, 32'(k), 32'(n));
    for (int i = 0; i < 16; i++)
      chk(rf[i] == erf[i], {tag, " R4 R6 R7 register result"}, rf[i], erf[i]);
    @(negedge clk);
    #1;
    chk(done_o == 1'b0, {tag, " R12 done single pulse"}, 32'(done_o), 0);
    if (inject) begin
      for (int j = 0; j < 4; j++) begin
        chk(!busy_o && !mem_valid_o, {tag, " R11 ignored start"}, 32'(busy_o), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #2_000_000;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !done_o && !mem_valid_o && !rf_we_o, "R12 reset state", 32'(busy_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: plain modes, store and load, mask {1,2,5}
    for (int md = 0; md < 4; md++) begin
      run_op(0, 0, md[1], md[0], 1, 0, 13, 16'h0026, 0, "R2 store");
      run_op(1, 0, md[1], md[0], 1, 0, 13, 16'h0026, 0, "R2 load");
    end
    // R3: stack forms, push and pop
    for (int md = 0; md < 4; md++) begin
      run_op(0, 1, md[1], md[0], 1, 0, 12, 16'h0F0A, 0, "R3 push");
      run_op(1, 1, md[1], md[0], 1, 0, 12, 16'h0F0A, 0, "R3 pop");
    end
    // R5: base stored as lowest / not lowest / no write-back
    run_op(0, 0, 0, 1, 1, 0, 1, 16'h0026, 0, "R5 base lowest");
    run_op(0, 0, 0, 1, 1, 0, 5, 16'h0026, 0, "R5 base not lowest");
    run_op(0, 0, 1, 0, 0, 0, 5, 16'h0026, 0, "R5 no wback");
    // R4: no write-back keeps base
    run_op(1, 0, 1, 0, 0, 0, 13, 16'h00F0, 0, "R4 base kept");
    // R6: load includes base
    run_op(1, 0, 1, 0, 1, 0, 4, 16'h00F0, 0, "R6 load base wb");
    run_op(1, 0, 0, 0, 0, 0, 4, 16'h00F0, 0, "R6 load base nowb");
    // R7: register 15 partial and full
    for (int i = 0; i < 1024; i++) mem[i] = ~rf[15];
    run_op(1, 0, 1, 0, 1, 0, 13, 16'h8001, 0, "R7 pc field only");
    for (int i = 0; i < 1024; i++) mem[i] = ~rf[15];
    run_op(1, 0, 1, 0, 1, 1, 13, 16'h8001, 0, "R7 full restore");
    // R8: store of register 15
    run_op(0, 1, 0, 1, 1, 0, 13, 16'hC000, 0, "R8 store r15");
    // R10: empty mask
    run_op(0, 0, 1, 1, 1, 0, 13, 16'h0000, 0, "R10 empty store");
    run_op(1, 1, 0, 1, 1, 0, 13, 16'h0000, 0, "R10 empty load");
    // R11: start while busy
    run_op(0, 0, 1, 0, 1, 0, 13, 16'h00F0, 1, "R11 busy start");
    // full mask both ways
    run_op(0, 1, 0, 1, 1, 0, 13, 16'hFFFF, 0, "R1 full push");
    run_op(1, 1, 0, 1, 1, 1, 13, 16'hFFFF, 0, "R1 full pop");

    for (int t = 0; t < 150; t++) begin
      logic [15:0] m;
      int b;
      m = 16'($urandom);
      if (t % 3 == 0) m = m & 16'($urandom);
      if (t % 17 == 0) m = '0;
      b = $urandom % 16;
      run_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), b, m, (t % 11 == 0), "R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule